// File: doc/BRIEF.md
# Synchronous Burst Memory with Flow-Through Reads

This block is an on-chip word memory that sits on a shared data bus and is driven by two independent masters: a processor and a cache controller. Each master has its own address strobe. At every rising clock edge the block samples three chip selects, the two strobes, an advance input and the write controls. From these it decides what kind of cycle this is:

- a sleep cycle,
- a deselect cycle,
- a burst start (read or write),
- a burst step,
- a burst hold.

Read data is flow-through. The word addressed at an edge appears on the read port in the cycle that follows that edge, with no extra pipeline stage.

A two-bit burst counter walks through four words after the start address. The walk is either linear or interleaved, as chosen by a static order pin. Writes are masked per byte lane, and each lane carries its own parity bit. The block has no bidirectional pin. Instead it produces a bus-drive signal that tells the surrounding pad logic when the read port may drive the shared bus; the read port is forced to zero whenever that signal is low. A sleep request idles the block while the memory contents are kept.

The block has no streaming interface. Every access is accepted on the edge where it is presented, so there is neither back-pressure nor a ready signal.

Top module: `sync_burst_mem`

## Requirements
- R1: An access starts only when the chip selects show cs1_n=0, cs2=1 and cs3_n=0 at an edge where a strobe is recognised. If any other select pattern appears at such an edge, the cycle is a deselect: nothing is written, and bus_drive is 0 in the following cycle.
- R2: The processor strobe (cpu_stb_n=0) is recognised only while cs1_n=0. It always starts a read, whatever the write inputs show. It wins when both strobes are low. While cs1_n=1, a low processor strobe with ctl_stb_n=1 acts as a burst step or hold, depending on adv_n.
- R3: When the controller strobe is low, the processor strobe is not recognised, and the write inputs request a write, the lanes selected by the write inputs are written at the edge itself. The target is the address on addr, and the data is the data on wdata.
- R4: A write is requested when wall_n=0, or when wbyte_n=0 and at least one lane_sel_n bit is 0. wall_n=0 writes all four lanes, whatever lane_sel_n and wbyte_n show. If wbyte_n=1 and wall_n=1, no write takes place.
- R5: Lane k is data bits [9k+8:9k], with bit 9k+8 as its parity bit. Lane k is written only when lane_sel_n[k]=0 (or when wall_n=0). Any mix of lanes is allowed.
- R6: rdata shows the word at the current burst address in the cycle right after the edge that set that address. A word written by a controller-strobe edge can be read back at the next strobe edge.
- R7: bus_drive is 1 only when oe_n=0, the last strobe-started access was a read, and no write has happened since. After reset bus_drive is 0. When bus_drive is 0, rdata is 0.
- R8: The first cycle of a read started directly after a deselect, a sleep cycle or reset has bus_drive=0, even when oe_n=0. The following cycle drives normally.
- R9: With no strobe recognised and adv_n=0, the burst counter steps, and the access at that edge (a read, or a write per R4) uses the stepped address. For a start offset s and step i, the low two address bits are (s+i) mod 4 when lin_order=1, and s XOR i when lin_order=0. The sequence wraps after four words.
- R10: With no strobe recognised and adv_n=1, the address stays the same, and a write per R4 goes to that address.
- R11: asleep goes to 1 two edges after sleep_req rises, and goes back to 0 two edges after it falls. While sleep_req is 1, and for the two edges after it falls, strobes and write inputs have no effect and bus_drive is 0. Memory contents are kept. A strobe in those two recovery edges is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (8) | Word address sampled on a strobe edge |
| cs1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wall_n | input | 1 | Write all lanes, active low |
| wbyte_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES (4) | Per-lane write select, active low |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved; static |
| oe_n | input | 1 | Output enable, active low, not sampled |
| sleep_req | input | 1 | Sleep request, active high |
| wdata | input | 36 | Write data, four 9-bit lanes |
| rdata | output | 36 | Flow-through read data, 0 when not driving |
| bus_drive | output | 1 | High when the read port may drive the shared bus |
| asleep | output | 1 | High while in sleep |

## Verification
The embedded assertions check the following on every edge:

- a deselect or sleep cycle is followed by an undriven bus;
- a write cycle never drives;
- a processor-started cycle never writes;
- the output mask lasts exactly one cycle;
- no write is enabled while asleep;
- a linear step advances the low address by one, and a hold keeps it;
- no strobe arrives in the recovery window.

The burst walks for both orders, how byte lanes merge, data surviving sleep, and strobe collisions are not visible to any single-edge property. Only the bench's reference model can show them, by comparing every read word against its own memory image.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [2:0] {
    CY_SLEEP,
    CY_DESEL,
    CY_BEGIN_RD,
    CY_BEGIN_WR,
    CY_NEXT,
    CY_HOLD
  } cyc_e;
endpackage

// File: rtl/sbm_burst_seq.sv
module sbm_burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             linear,
  input  logic [CNT_W-1:0] load_lo,
  output logic [CNT_W-1:0] lo,
  output logic [CNT_W-1:0] lo_adv
);
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_adv;

  function automatic logic [CNT_W-1:0] walk(input logic [CNT_W-1:0] s,
                                            input logic [CNT_W-1:0] c,
                                            input logic lin);
    logic [CNT_W-1:0] sum;
    sum = s + c;
    return lin ? sum : (s ^ c);
  endfunction

  assign cnt_adv = cnt_q + 1'b1;
  assign lo      = walk(start_q, cnt_q, linear);
  assign lo_adv  = walk(start_q, cnt_adv, linear);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      start_q <= load_lo;
      cnt_q   <= '0;
    end else if (step) begin
      cnt_q <= cnt_adv;
    end
  end

  // R9: a linear step moves the low address up by one, wrapping
  p_linear_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && linear) |=>
      (lo == CNT_W'($past(lo) + 1'b1)) || !$stable(linear));

  // R9: any step changes the low address
  p_step_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (lo != $past(lo)) || !$stable(linear));

  // R10: without step or load the address holds
  p_hold_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(lo) || !$stable(linear));
endmodule

// File: rtl/sbm_wr_decode.sv
module sbm_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             wall_n,
  input  logic             wbyte_n,
  input  logic [LANES-1:0] sel_n,
  input  logic             block,
  output logic             wr_req,
  output logic [LANES-1:0] lane_we
);
  logic [LANES-1:0] raw;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign raw[k] = !wall_n || (!wbyte_n && !sel_n[k]);
    end
  endgenerate

  assign wr_req  = |raw;
  assign lane_we = block ? '0 : raw;
endmodule

// File: rtl/sbm_cycle_ctl.sv
module sbm_cycle_ctl import sbm_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic cs1_n,
  input  logic cs2,
  input  logic cs3_n,
  input  logic cpu_stb_n,
  input  logic ctl_stb_n,
  input  logic adv_n,
  input  logic wr_req,
  input  logic sleep_req,
  output cyc_e kind,
  output logic proc_start,
  output logic asleep
);
  logic s1_q, s2_q;
  logic hold, sel_ok;

  assign hold       = sleep_req || s1_q || s2_q;
  assign sel_ok     = !cs1_n && cs2 && !cs3_n;
  assign proc_start = !cpu_stb_n && !cs1_n;
  assign asleep     = s2_q;

  always_comb begin
    if (hold)                         kind = CY_SLEEP;
    else if (proc_start || !ctl_stb_n) begin
      if (!sel_ok)                    kind = CY_DESEL;
      else if (proc_start || !wr_req) kind = CY_BEGIN_RD;
      else                            kind = CY_BEGIN_WR;
    end
    else if (!adv_n)                  kind = CY_NEXT;
    else                              kind = CY_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= sleep_req;
      s2_q <= s1_q;
    end
  end

  // R11: no strobe may arrive while recovering from sleep
  p_no_strobe_recovery_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_req && (s1_q || s2_q)) |-> (cpu_stb_n && ctl_stb_n));
endmodule

// File: rtl/sync_burst_mem.sv
module sync_burst_mem import sbm_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int CNT_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      cs1_n,
  input  logic                      cs2,
  input  logic                      cs3_n,
  input  logic                      cpu_stb_n,
  input  logic                      ctl_stb_n,
  input  logic                      adv_n,
  input  logic                      wall_n,
  input  logic                      wbyte_n,
  input  logic [LANES-1:0]          lane_sel_n,
  input  logic                      lin_order,
  input  logic                      oe_n,
  input  logic                      sleep_req,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      bus_drive,
  output logic                      asleep
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - CNT_W;

  cyc_e              kind;
  logic              proc_start, wr_req;
  logic [LANES-1:0]  lane_we, lane_en;
  logic [CNT_W-1:0]  lo, lo_adv;
  logic [HI_W-1:0]   base_hi;
  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic [DATA_W-1:0] rd_word;
  logic              load, step, wr_any;
  logic              rd_live_q, desel_q, mask_q, wr_last_q;

  sbm_cycle_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
    .wr_req(wr_req), .sleep_req(sleep_req),
    .kind(kind), .proc_start(proc_start), .asleep(asleep)
  );

  sbm_wr_decode #(.LANES(LANES)) u_dec (
    .wall_n(wall_n), .wbyte_n(wbyte_n), .sel_n(lane_sel_n),
    .block(proc_start), .wr_req(wr_req), .lane_we(lane_we)
  );

  assign load = (kind == CY_BEGIN_RD) || (kind == CY_BEGIN_WR);
  assign step = (kind == CY_NEXT);

  sbm_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .linear(lin_order),
    .load_lo(addr[CNT_W-1:0]), .lo(lo), .lo_adv(lo_adv)
  );

  assign cur_addr = {base_hi, lo};

  always_comb begin
    case (kind)
      CY_BEGIN_WR: wr_addr = addr;
      CY_NEXT:     wr_addr = {base_hi, lo_adv};
      default:     wr_addr = cur_addr;
    endcase
  end

  assign lane_en = (kind == CY_BEGIN_WR || kind == CY_NEXT || kind == CY_HOLD)
                   ? lane_we : '0;
  assign wr_any  = |lane_en;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_bank
      logic [LANE_W-1:0] bank [DEPTH];
      always_ff @(posedge clk) begin
        if (lane_en[k]) bank[wr_addr] <= wdata[k*LANE_W +: LANE_W];
      end
      assign rd_word[k*LANE_W +: LANE_W] = bank[cur_addr];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi   <= '0;
      rd_live_q <= 1'b0;
      desel_q   <= 1'b1;
      mask_q    <= 1'b0;
      wr_last_q <= 1'b0;
    end else begin
      wr_last_q <= wr_any;
      if (load) base_hi <= addr[ADDR_W-1:CNT_W];
      case (kind)
        CY_SLEEP, CY_DESEL: begin
          rd_live_q <= 1'b0;
          desel_q   <= 1'b1;
          mask_q    <= 1'b0;
        end
        CY_BEGIN_RD: begin
          rd_live_q <= 1'b1;
          mask_q    <= desel_q;
          desel_q   <= 1'b0;
        end
        CY_BEGIN_WR: begin
          rd_live_q <= 1'b0;
          mask_q    <= 1'b0;
          desel_q   <= 1'b0;
        end
        default: begin
          mask_q <= 1'b0;
          if (wr_any) rd_live_q <= 1'b0;
        end
      endcase
    end
  end

  assign bus_drive = rd_live_q && !oe_n && !mask_q;
  assign rdata     = bus_drive ? rd_word : '0;

  // R1: deselect or sleep leaves the bus undriven next cycle
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CY_DESEL || kind == CY_SLEEP) |=> !bus_drive);

  // R2: a processor-started access never writes
  p_proc_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CY_BEGIN_RD) |=> !wr_last_q);

  // R7: the cycle after a write never drives the bus
  p_write_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last_q |-> !bus_drive);

  // R8: the output mask lasts one cycle only
  p_mask_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> !mask_q);

  // R11: nothing is written while asleep
  p_sleep_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (lane_en == '0));
endmodule

// File: tb/tb_sync_burst_mem.sv
module tb_sync_burst_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        cs1_n, cs2, cs3_n, cpu_stb_n, ctl_stb_n, adv_n;
  logic        wall_n, wbyte_n, oe_n, sleep_req;
  logic        lin_order = 1'b1;
  logic [3:0]  lane_sel_n;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        bus_drive, asleep;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  sync_burst_mem dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
    .adv_n(adv_n), .wall_n(wall_n), .wbyte_n(wbyte_n),
    .lane_sel_n(lane_sel_n), .lin_order(lin_order), .oe_n(oe_n),
    .sleep_req(sleep_req), .wdata(wdata), .rdata(rdata),
    .bus_drive(bus_drive), .asleep(asleep)
  );

  // reference model state
  logic [35:0] m_mem [256];
  int m_base = 0, m_start = 0, m_cnt = 0;
  bit m_rdlive = 0, m_desel = 1, m_mask = 0, m_s1 = 0, m_s2 = 0;

  function automatic int m_lo(int s, int c);
    return lin_order ? ((s + c) % 4) : (s ^ c);
  endfunction

  task automatic m_write(int a, logic [3:0] wm);
    for (int k = 0; k < 4; k++)
      if (wm[k]) m_mem[a][k*9 +: 9] = wdata[k*9 +: 9];
  endtask

  task automatic m_load();
    m_base = int'(addr) >> 2;
    m_start = int'(addr) & 3;
    m_cnt = 0;
  endtask

  task automatic model_edge();
    bit hold, pst, sel_ok;
    logic [3:0] wm;
    hold = sleep_req || m_s1 || m_s2;
    m_s2 = m_s1;
    m_s1 = sleep_req;
    for (int k = 0; k < 4; k++) wm[k] = !wall_n || (!wbyte_n && !lane_sel_n[k]);
    pst = !cpu_stb_n && !cs1_n;
    sel_ok = !cs1_n && cs2 && !cs3_n;
    if (hold) begin
      m_rdlive = 0; m_desel = 1; m_mask = 0;
    end else if (pst || !ctl_stb_n) begin
      if (!sel_ok) begin
        m_rdlive = 0; m_desel = 1; m_mask = 0;
      end else if (pst || wm == 4'b0) begin
        m_load(); m_mask = m_desel; m_desel = 0; m_rdlive = 1;
      end else begin
        m_load(); m_write(int'(addr), wm);
        m_rdlive = 0; m_mask = 0; m_desel = 0;
      end
    end else begin
      if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      m_mask = 0;
      if (wm != 4'b0) begin
        m_write(m_base * 4 + m_lo(m_start, m_cnt), wm);
        m_rdlive = 0;
      end
    end
  endtask

  task automatic check(string tag, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    bit exp_drv;
    logic [35:0] exp_data;
    exp_drv  = m_rdlive && !oe_n && !m_mask;
    exp_data = exp_drv ? m_mem[m_base * 4 + m_lo(m_start, m_cnt)] : 36'h0;
    check(tag, "bus_drive", {35'h0, bus_drive}, {35'h0, exp_drv});
    check(tag, "rdata", rdata, exp_data);
    check(tag, "asleep", {35'h0, asleep}, {35'h0, m_s2});
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_idle();
    cs1_n = 0; cs2 = 1; cs3_n = 0;
    cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1;
    wall_n = 1; wbyte_n = 1; lane_sel_n = 4'hF;
    oe_n = 0; sleep_req = 0;
  endtask

  task automatic cwr(int a, logic [35:0] d);
    set_idle(); ctl_stb_n = 0; addr = 8'(a); wall_n = 0; wdata = d;
    cyc("R3");
  endtask

  task automatic prd(int a, string tag);
    set_idle(); cpu_stb_n = 0; addr = 8'(a);
    cyc(tag);
  endtask

  task automatic crd(int a, string tag);
    set_idle(); ctl_stb_n = 0; addr = 8'(a);
    cyc(tag);
  endtask

  task automatic nxt(string tag);
    set_idle(); adv_n = 0;
    cyc(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    set_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R7 reset", "bus_drive", {35'h0, bus_drive}, 36'h0);
    check("R11 reset", "asleep", {35'h0, asleep}, 36'h0);

    // R3/R4: fill every word through controller-strobe writes
    for (int a = 0; a < 256; a++)
      cwr(a, 36'(a) * 36'h0_1357_9BDF + 36'h3_0000_0011);

    // R1: select pattern wrong, write must not land
    set_idle(); cs2 = 0; ctl_stb_n = 0; wall_n = 0; addr = 8'd20; wdata = '1;
    cyc("R1");
    // R8: first read after deselect is masked, then linear burst R9
    lin_order = 1'b1;
    prd(22, "R8");
    nxt("R9 linear");
    nxt("R9 linear");
    nxt("R9 linear");
    nxt("R9 wrap R1");

    // R9: interleaved order from offset 1
    set_idle(); lin_order = 1'b0; cyc("R10 idle");
    prd(37, "R9 interleaved");
    for (int i = 0; i < 4; i++) nxt("R9 interleaved");
    set_idle(); lin_order = 1'b1; cyc("R10 idle");

    // R2: both strobes and write inputs low -> read only
    set_idle(); cpu_stb_n = 0; ctl_stb_n = 0; wall_n = 0; addr = 8'd50; wdata = '1;
    cyc("R2 collision");
    // R2: processor strobe ignored while cs1_n high -> burst step
    set_idle(); cs1_n = 1; cpu_stb_n = 0; adv_n = 0;
    cyc("R2 cs1 high");

    // R2: processor start with write inputs -> read, then writes follow
    set_idle(); cpu_stb_n = 0; addr = 8'd60; wall_n = 0; wdata = 36'hF_0F0F_0F0F;
    cyc("R2 proc start");
    set_idle(); wbyte_n = 0; lane_sel_n = 4'b1010; wdata = 36'hA_BCDE_F012;
    cyc("R10 R5 suspend write");
    set_idle(); adv_n = 0; wbyte_n = 0; lane_sel_n = 4'b1110; wdata = 36'h5_5555_5555;
    cyc("R9 R5 step write");
    set_idle(); adv_n = 0; wall_n = 0; wbyte_n = 1; lane_sel_n = 4'hF; wdata = 36'h1_2345_6789;
    cyc("R4 global write");
    set_idle(); lane_sel_n = 4'h0; wdata = '1;
    cyc("R4 R7 no write");
    crd(60, "R5 readback");
    nxt("R5 readback");
    nxt("R4 readback");
    nxt("R4 readback");

    // R7: oe_n high stops driving
    set_idle(); oe_n = 1; cyc("R7 oe");
    set_idle(); cyc("R7 oe back");

    // R6: controller write then immediate read-back
    cwr(70, 36'hC_AFE0_1234);
    set_idle(); cyc("R7 after write");
    crd(70, "R6");

    // R11: sleep entry, blocked write, recovery, contents kept
    set_idle(); sleep_req = 1; cyc("R11 enter");
    set_idle(); sleep_req = 1; cyc("R11 enter");
    check("R11", "asleep", {35'h0, asleep}, 36'h1);
    set_idle(); sleep_req = 1; ctl_stb_n = 0; wall_n = 0; addr = 8'd70; wdata = '0;
    cyc("R11 blocked write");
    set_idle(); cyc("R11 recovery");
    set_idle(); cyc("R11 recovery");
    check("R11", "asleep", {35'h0, asleep}, 36'h0);
    crd(70, "R11 R8 first read");
    set_idle(); cyc("R11 contents");

    done = 1;
    finish_run();
  end
endmodule